// File: doc/BRIEF.md
# Sparse-Stamp Oscillation Count and Deviation Estimator

This block takes the timestamps captured for one oscillator channel, reconstructs how many oscillator cycles lie between two successive captures, and turns that into a signed frequency-deviation figure proportional to the channel's input voltage. Each stamp is an 8-bit Gray-coded snapshot of a free-running tick counter taken on an oscillator rising edge. Because a shared capture path visits a channel only now and then, many edges are lost between two stamps. The number of elapsed cycles is therefore inferred by assuming the input is small. The tick gap is multiplied by the nominal free-running rate and rounded to the nearest integer.

Software supplies the nominal rate as oscillations per tick, with 12 fractional bits. It also supplies a gain term, the reciprocal of the oscillator sensitivity, with 8 fractional bits. For every usable stamp pair the block reports the tick gap, the inferred cycle count, an error flag and the scaled deviation. The estimate holds only while the true count is within half a cycle of the nominal prediction. Any error in the nominal rate appears as an input offset. When every edge is captured, the inferred count is one.

Top module: `tsr_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output register clears to zero and `est_valid` is low.
- R2: The first stamp accepted after reset produces no result. It only becomes the reference for the next stamp.
- R3: A stamp whose channel differs from the previous stamp's channel produces no result. It becomes the new reference.
- R4: The stamp is Gray coded (gray = bin ^ (bin >> 1)). `est_ticks` equals the decoded current stamp minus the decoded previous stamp, modulo 256.
- R5: `est_count` equals floor((ticks * cfg_fnom + 2048) / 4096), so a rate exactly on the half rounds up. `cfg_fnom` counts oscillations per tick with 12 fractional bits.
- R6: If the rounded count is zero, `est_count` is forced to 1 and `est_err` is raised. Otherwise `est_err` is low.
- R7: `est_dev` equals ((floor(est_count * 4096 / ticks) - cfg_fnom) * cfg_gain_inv) shifted right arithmetically by 8 bits, as a signed value.
- R8: A zero tick gap gives `est_count` = 1, `est_err` high and `est_dev` = 0.
- R9: A result appears as a one-cycle `est_valid` pulse, two clock edges after the edge that samples `stamp_valid` high.
- R10: While `stamp_valid` is low the stamp and channel inputs are ignored. `est_valid` stays low and the data outputs keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stamp_valid | input | 1 | Stamp strobe |
| stamp_chan | input | 5 | Channel the stamp belongs to |
| stamp_gray | input | 8 | Gray-coded counter snapshot |
| cfg_fnom | input | 16 | Nominal oscillations per tick, 12 fractional bits |
| cfg_gain_inv | input | 16 | Reciprocal oscillator gain, 8 fractional bits |
| est_valid | output | 1 | Result strobe |
| est_count | output | 13 | Inferred oscillation count |
| est_ticks | output | 8 | Wrapped tick gap |
| est_err | output | 1 | Count clamped from zero |
| est_dev | output | 35 | Signed scaled frequency deviation |

## Verification
The stimulus includes a dense pattern where every edge is captured, which must infer a count of one, and sparse gaps that must infer counts of several cycles. Stamp pairs that straddle the counter wrap separate a correct modulo difference from a plain subtraction. A rate of exactly one half per tick puts the rounding on its boundary. Gaps that are too short, including a zero gap, must drive the clamp and error path. Channel changes, a first stamp after reset, and idle cycles with changing stamp values must stay silent and leave the outputs unchanged. Gaps slightly above and below the nominal period give positive and negative deviations, which expose the sign handling and the floor shift.

// File: rtl/tsr_pkg.sv
// Shared defaults for the sparse-stamp estimator.
// Assumes all instances take their widths from these values unless overridden.
package tsr_pkg;
    localparam int STAMP_W_D = 8;   // tick counter width
    localparam int CH_W_D    = 5;   // channel index width
    localparam int FNOM_W_D  = 16;  // nominal rate width
    localparam int FRAC_W_D  = 12;  // nominal rate fractional bits
    localparam int K_W_D     = 16;  // gain reciprocal width
    localparam int K_FRAC_D  = 8;   // gain reciprocal fractional bits
endpackage

// File: rtl/tsr_gray_dec.sv
// Gray to binary decoder.
// Assumes a standard reflected Gray code; purely combinational.
module tsr_gray_dec #(
    parameter int W = tsr_pkg::STAMP_W_D
) (
    input  logic [W-1:0] gray,
    output logic [W-1:0] bin
);
    // each binary bit is the parity of the Gray bits at and above it
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign bin[i] = ^gray[W-1:i];
    end
endmodule

// File: rtl/tsr_delta.sv
// Keeps the previous stamp and channel and forms the wrapped tick gap.
// Assumes each gap spans less than one counter wrap. A first stamp or a
// channel change only primes the reference and emits nothing.
module tsr_delta #(
    parameter int STAMP_W = tsr_pkg::STAMP_W_D,
    parameter int CH_W    = tsr_pkg::CH_W_D
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [CH_W-1:0]    in_chan,
    input  logic [STAMP_W-1:0] in_bin,
    output logic               d_valid,
    output logic [STAMP_W-1:0] d_tick
);
    logic               primed;
    logic [STAMP_W-1:0] prev_bin;
    logic [CH_W-1:0]    prev_chan;

    // reference register and gap stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            primed    <= 1'b0;
            prev_bin  <= '0;
            prev_chan <= '0;
            d_valid   <= 1'b0;
            d_tick    <= '0;
        end else begin
            d_valid <= 1'b0;
            if (in_valid) begin
                primed    <= 1'b1;
                prev_bin  <= in_bin;
                prev_chan <= in_chan;
                if (primed && (in_chan == prev_chan)) begin
                    d_valid <= 1'b1;
                    d_tick  <= in_bin - prev_bin;
                end
            end
        end
    end

    AST_PRIME_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !primed) |=> !d_valid); // R2
    AST_CHAN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && primed && (in_chan != prev_chan)) |=> !d_valid); // R3
    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !d_valid); // R10
endmodule

// File: rtl/tsr_count.sv
// Infers the elapsed oscillation count from a tick gap and the nominal
// rate (oscillations per tick, FRAC_W fractional bits), rounding half up.
// Assumes the input is small enough that rounding picks the true count.
module tsr_count #(
    parameter int STAMP_W = tsr_pkg::STAMP_W_D,
    parameter int FNOM_W  = tsr_pkg::FNOM_W_D,
    parameter int FRAC_W  = tsr_pkg::FRAC_W_D,
    localparam int PW     = STAMP_W + FNOM_W + 1,
    localparam int CNT_W  = PW - FRAC_W
) (
    input  logic [STAMP_W-1:0] tick,
    input  logic [FNOM_W-1:0]  fnom,
    output logic [CNT_W-1:0]   count,
    output logic               clamped
);
    localparam logic [PW-1:0] HALF = PW'(1) << (FRAC_W - 1);

    logic [PW-1:0]    scaled;
    logic [CNT_W-1:0] rounded;

    // round-half-up product and zero clamp
    always_comb begin
        scaled  = PW'(tick) * PW'(fnom) + HALF;
        rounded = scaled[PW-1:FRAC_W];
        clamped = (rounded == '0);
        count   = clamped ? CNT_W'(1) : rounded;
    end
endmodule

// File: rtl/tsr_dev.sv
// Converts count and tick gap into a scaled deviation:
// ((count/ticks in FRAC_W fixed point) - fnom) * gain_inv >>> K_FRAC.
// Assumes a zero gap is an error and yields zero.
module tsr_dev #(
    parameter int STAMP_W = tsr_pkg::STAMP_W_D,
    parameter int FNOM_W  = tsr_pkg::FNOM_W_D,
    parameter int FRAC_W  = tsr_pkg::FRAC_W_D,
    parameter int K_W     = tsr_pkg::K_W_D,
    parameter int K_FRAC  = tsr_pkg::K_FRAC_D,
    parameter int CNT_W   = STAMP_W + FNOM_W + 1 - FRAC_W,
    localparam int QW     = CNT_W + FRAC_W,
    localparam int MW     = QW + 1 + K_W + 1,
    localparam int EST_W  = MW - K_FRAC
) (
    input  logic [STAMP_W-1:0]     tick,
    input  logic [CNT_W-1:0]       count,
    input  logic [FNOM_W-1:0]      fnom,
    input  logic [K_W-1:0]         gain_inv,
    output logic signed [EST_W-1:0] dev
);
    logic [QW-1:0]          numer;
    logic [QW-1:0]          denom;
    logic [QW-1:0]          quot;
    logic signed [QW:0]     diff;
    logic signed [K_W:0]    gain_s;
    logic signed [MW-1:0]   prod;
    logic signed [MW-1:0]   shifted;

    // rate estimate, offset removal and gain scaling
    always_comb begin
        numer   = QW'(count) << FRAC_W;
        denom   = (tick == '0) ? QW'(1) : QW'(tick);
        quot    = numer / denom;
        diff    = $signed({1'b0, quot}) - $signed((QW + 1)'(fnom));
        gain_s  = $signed({1'b0, gain_inv});
        prod    = MW'(diff) * MW'(gain_s);
        shifted = prod >>> K_FRAC;
        dev     = (tick == '0) ? '0 : shifted[EST_W-1:0];
    end
endmodule

// File: rtl/tsr_top.sv
// Sparse-stamp oscillation count and deviation estimator, one channel
// stream at a time. Stage 1 decodes and differences stamps; stage 2
// infers the count and registers count, gap, error and deviation.
// Assumes configuration is stable while a stamp is in flight.
module tsr_top #(
    parameter int STAMP_W = tsr_pkg::STAMP_W_D,
    parameter int CH_W    = tsr_pkg::CH_W_D,
    parameter int FNOM_W  = tsr_pkg::FNOM_W_D,
    parameter int FRAC_W  = tsr_pkg::FRAC_W_D,
    parameter int K_W     = tsr_pkg::K_W_D,
    parameter int K_FRAC  = tsr_pkg::K_FRAC_D,
    localparam int CNT_W  = STAMP_W + FNOM_W + 1 - FRAC_W,
    localparam int EST_W  = CNT_W + FRAC_W + 1 + K_W + 1 - K_FRAC
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    stamp_valid,
    input  logic [CH_W-1:0]         stamp_chan,
    input  logic [STAMP_W-1:0]      stamp_gray,
    input  logic [FNOM_W-1:0]       cfg_fnom,
    input  logic [K_W-1:0]          cfg_gain_inv,
    output logic                    est_valid,
    output logic [CNT_W-1:0]        est_count,
    output logic [STAMP_W-1:0]      est_ticks,
    output logic                    est_err,
    output logic signed [EST_W-1:0] est_dev
);
    logic [STAMP_W-1:0]      stamp_bin;
    logic                    d_valid;
    logic [STAMP_W-1:0]      d_tick;
    logic [CNT_W-1:0]        c_count;
    logic                    c_clamped;
    logic signed [EST_W-1:0] c_dev;

    tsr_gray_dec #(.W(STAMP_W)) u_dec (
        .gray (stamp_gray),
        .bin  (stamp_bin)
    );

    tsr_delta #(.STAMP_W(STAMP_W), .CH_W(CH_W)) u_delta (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (stamp_valid),
        .in_chan  (stamp_chan),
        .in_bin   (stamp_bin),
        .d_valid  (d_valid),
        .d_tick   (d_tick)
    );

    tsr_count #(.STAMP_W(STAMP_W), .FNOM_W(FNOM_W), .FRAC_W(FRAC_W)) u_count (
        .tick    (d_tick),
        .fnom    (cfg_fnom),
        .count   (c_count),
        .clamped (c_clamped)
    );

    tsr_dev #(.STAMP_W(STAMP_W), .FNOM_W(FNOM_W), .FRAC_W(FRAC_W),
              .K_W(K_W), .K_FRAC(K_FRAC), .CNT_W(CNT_W)) u_dev (
        .tick     (d_tick),
        .count    (c_count),
        .fnom     (cfg_fnom),
        .gain_inv (cfg_gain_inv),
        .dev      (c_dev)
    );

    // result registers: load on a gap, otherwise hold data and drop strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            est_valid <= 1'b0;
            est_count <= '0;
            est_ticks <= '0;
            est_err   <= 1'b0;
            est_dev   <= '0;
        end else begin
            est_valid <= d_valid;
            if (d_valid) begin
                est_count <= c_count;
                est_ticks <= d_tick;
                est_err   <= c_clamped;
                est_dev   <= c_dev;
            end
        end
    end

    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        d_valid |=> est_valid); // R9
    AST_CNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        est_valid |-> (est_count != '0)); // R6
    AST_ERR_IS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (est_valid && est_err) |-> (est_count == CNT_W'(1))); // R6
    AST_ZERO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (d_valid && (d_tick == '0)) |=> (est_err && (est_dev == '0))); // R8
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !d_valid |=> ($stable(est_ticks) && $stable(est_count) && $stable(est_dev))); // R10
endmodule

// File: tb/tb_tsr_top.sv
module tb_tsr_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stamp_valid = 1'b0;
    logic [4:0]  stamp_chan = '0;
    logic [7:0]  stamp_gray = '0;
    logic [15:0] cfg_fnom = 16'd160;
    logic [15:0] cfg_gain_inv = 16'd300;
    logic        est_valid;
    logic [12:0] est_count;
    logic [7:0]  est_ticks;
    logic        est_err;
    logic signed [34:0] est_dev;

    tsr_top dut (
        .clk(clk), .rst_n(rst_n), .stamp_valid(stamp_valid),
        .stamp_chan(stamp_chan), .stamp_gray(stamp_gray),
        .cfg_fnom(cfg_fnom), .cfg_gain_inv(cfg_gain_inv),
        .est_valid(est_valid), .est_count(est_count), .est_ticks(est_ticks),
        .est_err(est_err), .est_dev(est_dev)
    );

    always #4 clk = ~clk;

    typedef struct {
        int     due;
        int     tick;
        int     cnt;
        bit     err;
        longint dev;
        string  tag;
    } exp_t;

    exp_t   expq[$];
    exp_t   last;
    int     cyc = 0;
    int     n_chk = 0;
    int     n_bad = 0;
    bit     chk_on = 0;
    bit     done = 0;
    string  silent_tag = "R2";
    bit     m_primed = 0;
    int     m_ch = 0;
    int     m_prev = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input longint act,
                       input longint exp, input string what);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    // reference model for one stamp pair
    function automatic exp_t model(input int tick, input string tag);
        exp_t e;
        longint fn, gi, r, q, d;
        fn = longint'(cfg_fnom);
        gi = longint'(cfg_gain_inv);
        r = (longint'(tick) * fn + 2048) / 4096;
        e.tick = tick;
        e.err  = (r == 0);
        e.cnt  = (r == 0) ? 1 : int'(r);
        if (tick == 0) e.dev = 0;
        else begin
            q = (longint'(e.cnt) * 4096) / longint'(tick);
            d = (q - fn) * gi;
            e.dev = d >>> 8;
        end
        e.tag = tag;
        return e;
    endfunction

    task automatic send(input int ch, input int bin, input string tag);
        exp_t e;
        @(negedge clk);
        stamp_valid = 1'b1;
        stamp_chan  = 5'(ch);
        stamp_gray  = 8'(bin ^ (bin >> 1));
        if (!m_primed || ch != m_ch) begin
            silent_tag = tag;
        end else begin
            e = model((bin - m_prev) & 255, tag);
            e.due = cyc + 2;
            expq.push_back(e);
        end
        m_primed = 1; m_ch = ch; m_prev = bin;
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            stamp_valid = 1'b0;
            stamp_chan  = 5'(i * 7 + 3);
            stamp_gray  = 8'(i * 37 + 11);
            if (expq.size() == 0) silent_tag = tag;
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (chk_on) begin
            if (expq.size() > 0 && expq[0].due == cyc) begin
                exp_t e;
                e = expq.pop_front();
                chk(est_valid == 1'b1, "R9", est_valid, 1, {e.tag, " strobe"});
                chk(int'(est_ticks) == e.tick, "R4", est_ticks, e.tick, {e.tag, " ticks"});
                chk(int'(est_count) == e.cnt, "R5", est_count, e.cnt, {e.tag, " count"});
                chk(est_err == e.err, "R6", est_err, e.err, {e.tag, " err"});
                chk(longint'(est_dev) == e.dev, "R7", longint'(est_dev), e.dev, {e.tag, " dev"});
                last = e;
            end else begin
                chk(est_valid == 1'b0, silent_tag, est_valid, 0, "no strobe expected");
                chk(int'(est_ticks) == last.tick && int'(est_count) == last.cnt &&
                    longint'(est_dev) == last.dev, "R10", est_ticks, last.tick, "held outputs");
            end
        end
    end

    initial begin
        last.tick = 0; last.cnt = 0; last.err = 0; last.dev = 0; last.tag = "R1";
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(est_valid == 1'b0, "R1", est_valid, 0, "valid in reset");
        chk(est_count == '0, "R1", est_count, 0, "count in reset");
        chk(est_dev == '0, "R1", est_dev, 0, "dev in reset");
        rst_n = 1'b1;
        chk_on = 1;
        // R2: first stamp only primes; then dense capture, count one
        send(0, 10, "R2");
        idle(4, "R10");
        send(0, 35, "R5 dense");
        send(0, 60, "R5 dense");
        send(0, 87, "R7 slow");
        send(0, 110, "R7 fast");
        idle(5, "R10");
        // sparse gaps and counter wrap
        send(0, 240, "R5 sparse");
        send(0, 20, "R4 wrap");
        send(0, 150, "R5 sparse");
        idle(6, "R10");
        // R3: channel change primes only
        send(3, 200, "R3");
        idle(2, "R3");
        send(3, 226, "R3 after prime");
        idle(4, "R10");
        // R6/R8: short and zero gaps
        send(3, 231, "R6 short gap");
        send(3, 231, "R8 zero gap");
        idle(4, "R10");
        // R5: half rounding boundary at 0.5 oscillation per tick
        cfg_fnom = 16'd2048;
        cfg_gain_inv = 16'd40;
        idle(1, "R10");
        send(3, 232, "R5 half up");
        send(3, 235, "R5 three half");
        send(3, 236, "R5 half up");
        send(3, 250, "R7 even");
        idle(6, "R10");
        if (expq.size() != 0)
            chk(0, "R9", expq.size(), 0, "results never seen");
        done = 1;
    end

    initial begin
        for (int i = 0; i < 200000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL R9 watchdog: actual 0 expected 1 (run did not finish)");
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule